// File: doc/BRIEF.md
# Relocatable indexed control-register port

This block is the host-facing register front end of a peripheral on an 8-bit I/O bus. It occupies a pair of adjacent bus addresses. The even one is a write-only index port, and the odd one is a read/write data port that reaches the register currently selected by the index. The block holds the index, a parameterised bank of 8-bit control registers that drive the rest of the chip, and a write-only global register. That global register gates every other register and selects whether the write strobe is delayed.

The decode base is picked while reset is held. If chip select is low during reset, the pair sits at a fixed base. If chip select is high during reset, the block answers nothing until the first chip-selected write. That write's data bits 7..1 become the base. Bus inputs are taken as synchronous to the core clock. A register write takes effect on the clock edge at which the (optionally delayed) write strobe is first seen inactive.

Top module: `ioreg_port`

## Requirements
- R1: With chip select low during reset, the index port decodes at D6h and the data port at D7h, and accesses at any other address are ignored.
- R2: With chip select high during reset, nothing is decoded until the first write with chip select and write strobe both active. That write's data bits 7..1 become the base, with bit 0 read back as 0. That write changes no other register, and later writes never move the base.
- R3: Address bits 7..1 must equal the base for an access to be decoded, and address bit 0 selects index (0) or data (1). On a mismatch a write changes nothing and a read leaves drive_o low with data_o at 00h.
- R4: A read of the index port is never driven: drive_o stays low and data_o stays 00h.
- R5: After reset the global enable (index FFh, bit 0) is clear. While it is clear, writes to every index other than FFh are ignored, and data-port reads of every index other than FFh return 00h.
- R6: With the global enable set, indices 01h up to N_REGS are full 8-bit read/write registers, and index i appears on ctrl_o byte i-1. Index 00h reads back the decode base.
- R7: A data-port read of index FFh returns the version in bits 7..4 and 0 in bits 3..0, whatever was written to it.
- R8: Indices above N_REGS other than FFh ignore writes and read as 00h.
- R9: While index FFh bit 2 is clear (the reset value), a register write becomes visible on the third rising edge after the last edge at which the strobe was sampled active.
- R10: While index FFh bit 2 is set, a register write becomes visible on the first rising edge after the last edge at which the strobe was sampled active.
- R11: While reset is held and after its release, ctrl_o is all zero, glb_en_o is low and drive_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; its level during reset picks the decode mode |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| addr_i | input | 8 | Bus address |
| data_i | input | 8 | Bus write data |
| data_o | output | 8 | Bus read data, 00h when not driven |
| drive_o | output | 1 | Read data is valid and should be driven onto the bus |
| ctrl_o | output | N_REGS*8 | Control register contents, index i in byte i-1 |
| glb_en_o | output | 1 | Global enable state |

## Verification
Every cycle, the checker watches the read path. drive_o may rise only for a chip-selected data-port read, and never for an index-port read. Undriven data is zero. Index FFh always returns the version pattern. A disabled or unimplemented index reads as zero. The checker also confirms that the control outputs hold while the block is disabled and that a base, once known, never moves. The bench scenarios cover the rest: the mode picked at reset, learning the base from the first write, full round trips through the data port, and the exact commit edge with and without the strobe delay, which the checker does not attempt to predict.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
  typedef struct packed {
    logic       vld;
    logic [7:0] addr;
    logic [7:0] data;
  } wr_req_t;

  localparam logic [7:0] IDX_BASE   = 8'h00;
  localparam logic [7:0] IDX_GLOBAL = 8'hFF;
  localparam int unsigned GLB_EN_BIT  = 0;
  localparam int unsigned NODELAY_BIT = 2;
endpackage

// File: rtl/ioreg_wr_pipe.sv
module ioreg_wr_pipe
  import ioreg_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wr_req_t req_i,
  input  logic    bypass_i,
  output logic    commit_o,
  output wr_req_t cmt_req_o
);
  wr_req_t stage_q [DELAY_CYC];
  wr_req_t eff, hold_q;
  logic    prev_q;

  for (genvar s = 0; s < DELAY_CYC; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= req_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign eff = bypass_i ? req_i : stage_q[DELAY_CYC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= eff.vld;
      if (eff.vld) hold_q <= eff;
    end
  end

  // commit on the trailing edge of the effective strobe
  assign commit_o  = prev_q & ~eff.vld;
  assign cmt_req_o = hold_q;
endmodule

// File: rtl/ioreg_decode.sv
module ioreg_decode #(
  parameter logic [7:0] FIXED_BASE = 8'hD6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic [7:0] addr_i,
  input  logic       commit_i,
  input  logic [7:0] cmt_addr_i,
  input  logic [7:0] cmt_data_i,
  output logic [7:0] base_o,
  output logic       known_o,
  output logic       live_hit_o,
  output logic       cmt_hit_o
);
  logic       fixed_q, learned_q;
  logic [6:0] learn_q;

  // strap: chip-select level sampled while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) fixed_q <= ~cs_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      learned_q <= 1'b0;
      learn_q   <= '0;
    end else if (commit_i && !fixed_q && !learned_q) begin
      learned_q <= 1'b1;
      learn_q   <= cmt_data_i[7:1];
    end
  end

  assign known_o    = fixed_q | learned_q;
  assign base_o     = fixed_q ? {FIXED_BASE[7:1], 1'b0} : {learn_q, 1'b0};
  assign live_hit_o = known_o && (addr_i[7:1] == base_o[7:1]);
  assign cmt_hit_o  = known_o && (cmt_addr_i[7:1] == base_o[7:1]);
endmodule

// File: rtl/ioreg_bank.sv
module ioreg_bank
  import ioreg_pkg::*;
#(
  parameter int unsigned N_REGS  = 8,
  parameter logic [3:0]  VERSION = 4'h3,
  localparam int unsigned CW     = N_REGS * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_idx_i,
  input  logic          wr_dat_i,
  input  logic [7:0]    wdata_i,
  input  logic [7:0]    base_i,
  output logic [7:0]    idx_o,
  output logic [7:0]    rdata_o,
  output logic [CW-1:0] ctrl_o,
  output logic          glb_en_o,
  output logic          nodelay_o
);
  logic [7:0] idx_q;
  logic       glb_en_q, nodelay_q;
  logic [7:0] bank_q [N_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      glb_en_q  <= 1'b0;
      nodelay_q <= 1'b0;
    end else begin
      if (wr_idx_i) idx_q <= wdata_i;
      if (wr_dat_i && idx_q == IDX_GLOBAL) begin
        glb_en_q  <= wdata_i[GLB_EN_BIT];
        nodelay_q <= wdata_i[NODELAY_BIT];
      end
    end
  end

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank_q[i] <= '0;
      else if (wr_dat_i && glb_en_q && idx_q == 8'(i + 1)) bank_q[i] <= wdata_i;
    end
    assign ctrl_o[i*8 +: 8] = bank_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (idx_q == IDX_GLOBAL) begin
      rdata_o = {VERSION, 4'h0};
    end else if (glb_en_q) begin
      if (idx_q == IDX_BASE) rdata_o = base_i;
      for (int i = 0; i < N_REGS; i++) begin
        if (idx_q == 8'(i + 1)) rdata_o = bank_q[i];
      end
    end
  end

  assign idx_o     = idx_q;
  assign glb_en_o  = glb_en_q;
  assign nodelay_o = nodelay_q;
endmodule

// File: rtl/ioreg_port.sv
module ioreg_port
  import ioreg_pkg::*;
#(
  parameter logic [7:0]  FIXED_BASE = 8'hD6,
  parameter int unsigned N_REGS     = 8,
  parameter logic [3:0]  VERSION    = 4'h3,
  parameter int unsigned DELAY_CYC  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                wr_ni,
  input  logic                rd_ni,
  input  logic [7:0]          addr_i,
  input  logic [7:0]          data_i,
  output logic [7:0]          data_o,
  output logic                drive_o,
  output logic [N_REGS*8-1:0] ctrl_o,
  output logic                glb_en_o
);
  wr_req_t    req, cmt_req;
  logic       commit, nodelay;
  logic [7:0] base_w, idx_q, rdata;
  logic       known_w, live_hit, cmt_hit;

  assign req = '{vld: ~cs_ni & ~wr_ni, addr: addr_i, data: data_i};

  ioreg_wr_pipe #(.DELAY_CYC(DELAY_CYC)) u_pipe (
    .clk_i, .rst_ni,
    .req_i     (req),
    .bypass_i  (nodelay),
    .commit_o  (commit),
    .cmt_req_o (cmt_req)
  );

  ioreg_decode #(.FIXED_BASE(FIXED_BASE)) u_dec (
    .clk_i, .rst_ni, .cs_ni, .addr_i,
    .commit_i   (commit),
    .cmt_addr_i (cmt_req.addr),
    .cmt_data_i (cmt_req.data),
    .base_o     (base_w),
    .known_o    (known_w),
    .live_hit_o (live_hit),
    .cmt_hit_o  (cmt_hit)
  );

  ioreg_bank #(.N_REGS(N_REGS), .VERSION(VERSION)) u_bank (
    .clk_i, .rst_ni,
    .wr_idx_i  (commit & cmt_hit & ~cmt_req.addr[0]),
    .wr_dat_i  (commit & cmt_hit &  cmt_req.addr[0]),
    .wdata_i   (cmt_req.data),
    .base_i    (base_w),
    .idx_o     (idx_q),
    .rdata_o   (rdata),
    .ctrl_o    (ctrl_o),
    .glb_en_o  (glb_en_o),
    .nodelay_o (nodelay)
  );

  assign drive_o = ~cs_ni & ~rd_ni & live_hit & addr_i[0];
  assign data_o  = drive_o ? rdata : 8'h00;
endmodule

// File: rtl/ioreg_port_chk.sv
module ioreg_port_chk #(
  parameter int unsigned N_REGS  = 8,
  parameter logic [3:0]  VERSION = 4'h3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_ni,
  input logic                rd_ni,
  input logic [7:0]          addr_i,
  input logic [7:0]          data_o,
  input logic                drive_o,
  input logic [N_REGS*8-1:0] ctrl_o,
  input logic                glb_en_o,
  input logic [7:0]          idx,
  input logic [7:0]          base,
  input logic                known
);
  a_r3_drive_only_data_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> (!cs_ni && !rd_ni && addr_i[0]));
  a_r3_quiet_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (data_o == 8'h00));
  a_r4_index_read_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni && !addr_i[0]) |-> !drive_o);
  a_r5_disabled_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && !glb_en_o && idx != 8'hFF) |-> (data_o == 8'h00));
  a_r5_bank_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_o |=> ($stable(ctrl_o) || glb_en_o));
  a_r7_version_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && idx == 8'hFF) |-> (data_o == {VERSION, 4'h0}));
  a_r8_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && idx > 8'(N_REGS) && idx != 8'hFF) |-> (data_o == 8'h00));
  a_r2_base_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    known |=> (known && $stable(base)));
endmodule

bind ioreg_port ioreg_port_chk #(.N_REGS(N_REGS), .VERSION(VERSION)) u_chk (
  .clk_i, .rst_ni, .cs_ni, .rd_ni, .addr_i, .data_o, .drive_o, .ctrl_o, .glb_en_o,
  .idx(idx_q), .base(base_w), .known(known_w)
);

// File: tb/tb_ioreg_port.sv
module tb_ioreg_port;
  localparam int CLK_PERIOD = 10;
  localparam int N_REGS = 8;
  localparam int NV = 30;
  // {op, req, addr, data, expected}; op 0 write, 1 read driven, 2 read undriven
  localparam logic [29:0] VEC [NV] = '{
    {2'd2, 4'd4, 8'hD6, 8'h00, 8'h00},  // R4
    {2'd0, 4'd5, 8'hD6, 8'h05, 8'h00},
    {2'd1, 4'd5, 8'hD7, 8'h00, 8'h00},  // R5
    {2'd0, 4'd5, 8'hD7, 8'hAA, 8'h00},
    {2'd1, 4'd5, 8'hD7, 8'h00, 8'h00},
    {2'd0, 4'd7, 8'hD6, 8'hFF, 8'h00},
    {2'd0, 4'd7, 8'hD7, 8'h01, 8'h00},
    {2'd1, 4'd7, 8'hD7, 8'h00, 8'h30},  // R7
    {2'd0, 4'd5, 8'hD6, 8'h05, 8'h00},
    {2'd1, 4'd5, 8'hD7, 8'h00, 8'h00},
    {2'd0, 4'd6, 8'hD7, 8'hAA, 8'h00},
    {2'd1, 4'd6, 8'hD7, 8'h00, 8'hAA},  // R6
    {2'd0, 4'd6, 8'hD6, 8'h01, 8'h00},
    {2'd0, 4'd6, 8'hD7, 8'h3C, 8'h00},
    {2'd1, 4'd6, 8'hD7, 8'h00, 8'h3C},
    {2'd0, 4'd6, 8'hD6, 8'h08, 8'h00},
    {2'd0, 4'd6, 8'hD7, 8'h81, 8'h00},
    {2'd1, 4'd6, 8'hD7, 8'h00, 8'h81},
    {2'd0, 4'd8, 8'hD6, 8'h09, 8'h00},
    {2'd0, 4'd8, 8'hD7, 8'h77, 8'h00},
    {2'd1, 4'd8, 8'hD7, 8'h00, 8'h00},  // R8
    {2'd0, 4'd8, 8'hD6, 8'hFE, 8'h00},
    {2'd1, 4'd8, 8'hD7, 8'h00, 8'h00},
    {2'd0, 4'd6, 8'hD6, 8'h00, 8'h00},
    {2'd1, 4'd6, 8'hD7, 8'h00, 8'hD6},
    {2'd2, 4'd3, 8'hC7, 8'h00, 8'h00},  // R3
    {2'd0, 4'd3, 8'hC6, 8'h05, 8'h00},
    {2'd1, 4'd3, 8'hD7, 8'h00, 8'hD6},
    {2'd2, 4'd1, 8'hD5, 8'h00, 8'h00},  // R1
    {2'd2, 4'd1, 8'hD8, 8'h00, 8'h00}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, wr_ni = 1'b1, rd_ni = 1'b1;
  logic [7:0] addr_i = '0, data_i = '0;
  logic [7:0] data_o;
  logic drive_o, glb_en_o;
  logic [N_REGS*8-1:0] ctrl_o;
  int total = 0, bad = 0;

  ioreg_port #(.N_REGS(N_REGS)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cs_lvl);
    @(negedge clk_i);
    rst_ni = 1'b0; cs_ni = cs_lvl;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    cs_ni = 1'b1; rst_ni = 1'b1;
  endtask

  task automatic strobe_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; data_i = d; cs_ni = 1'b0; wr_ni = 1'b0;
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    strobe_wr(a, d);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic drv, output logic [7:0] v);
    @(negedge clk_i);
    addr_i = a; cs_ni = 1'b0; rd_ni = 1'b0;
    #1;
    drv = drive_o; v = data_o;
    #1;
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic drv;
    logic [7:0] v;
    // fixed mode
    do_reset(1'b0);
    #1;
    chk(ctrl_o == '0, "R11 ctrl", int'(ctrl_o[31:0]), 0);
    chk(glb_en_o == 1'b0, "R11 en", glb_en_o, 0);
    chk(drive_o == 1'b0, "R11 drive", drive_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] rq;
      op = VEC[i][29:28]; rq = VEC[i][27:24];
      if (op == 2'd0) bus_wr(VEC[i][23:16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][23:16], drv, v);
        if (op == 2'd1)
          chk(drv && v == VEC[i][7:0], $sformatf("R%0d vec%0d", rq, i), {drv, v}, {1'b1, VEC[i][7:0]});
        else
          chk(!drv && v == 8'h00, $sformatf("R%0d vec%0d", rq, i), {drv, v}, 0);
      end
    end
    chk(ctrl_o[39:32] == 8'hAA, "R6 ctrl idx5", ctrl_o[39:32], 8'hAA);
    chk(ctrl_o[7:0] == 8'h3C, "R6 ctrl idx1", ctrl_o[7:0], 8'h3C);
    chk(ctrl_o[63:56] == 8'h81, "R6 ctrl idx8", ctrl_o[63:56], 8'h81);

    // R9: delayed strobe, commit on third edge
    bus_wr(8'hD6, 8'h02);
    strobe_wr(8'hD7, 8'h11);
    @(negedge clk_i);
    chk(ctrl_o[15:8] == 8'h00, "R9 edge1", ctrl_o[15:8], 0);
    @(negedge clk_i);
    chk(ctrl_o[15:8] == 8'h00, "R9 edge2", ctrl_o[15:8], 0);
    @(negedge clk_i);
    chk(ctrl_o[15:8] == 8'h11, "R9 edge3", ctrl_o[15:8], 8'h11);

    // R10: no delay
    bus_wr(8'hD6, 8'hFF);
    bus_wr(8'hD7, 8'h05);
    bus_wr(8'hD6, 8'h02);
    strobe_wr(8'hD7, 8'h22);
    @(negedge clk_i);
    chk(ctrl_o[15:8] == 8'h22, "R10 edge1", ctrl_o[15:8], 8'h22);
    bus_wr(8'hD6, 8'hFF);
    bus_rd(8'hD7, drv, v);
    chk(drv && v == 8'h30, "R7 low bits hidden", v, 8'h30);

    // R5: disable again
    bus_wr(8'hD7, 8'h00);
    chk(glb_en_o == 1'b0, "R5 disabled", glb_en_o, 0);
    bus_wr(8'hD6, 8'h02);
    bus_wr(8'hD7, 8'h99);
    chk(ctrl_o[15:8] == 8'h22, "R5 write ignored", ctrl_o[15:8], 8'h22);
    bus_rd(8'hD7, drv, v);
    chk(drv && v == 8'h00, "R5 read zero", v, 0);

    // programmable mode
    do_reset(1'b1);
    bus_rd(8'hD7, drv, v);
    chk(!drv, "R2 unknown base", drv, 0);
    bus_wr(8'h10, 8'h35);
    chk(ctrl_o == '0 && !glb_en_o, "R2 learn side effect", int'(ctrl_o[31:0]), 0);
    bus_rd(8'hD7, drv, v);
    chk(!drv, "R2 fixed pair gone", drv, 0);
    bus_rd(8'h35, drv, v);
    chk(drv && v == 8'h00, "R2 learned pair", {drv, v}, 9'h100);
    bus_wr(8'h34, 8'hFF);
    bus_wr(8'h35, 8'h01);
    bus_rd(8'h35, drv, v);
    chk(drv && v == 8'h30, "R2 version via learned", v, 8'h30);
    bus_wr(8'h10, 8'h77);
    bus_wr(8'h34, 8'h00);
    bus_rd(8'h35, drv, v);
    chk(drv && v == 8'h34, "R2 base readback", v, 8'h34);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule